// File: doc/BRIEF.md
# Double-Buffered Serial Byte Data Register

This block is the byte-wide data register between a processor-style register port and a bit-serial link. On the transmit side, a write lands in a holding (shadow) byte. The shadow byte moves into a shift register as soon as the shift register is free, and the bits go out most significant first, one per pulse of a shared bit strobe. On the receive side, the incoming bits collect in a receive shift register. Each completed byte is copied into a receive shadow byte, which the processor reads.

The transmit empty flag is raised when the first bit of a newly loaded byte has left the shift register, not when the byte is finished. The processor therefore has almost a whole byte time to supply the next byte. A write marked as last ends the frame cleanly on a byte boundary. If the processor supplies nothing in time (underrun), the transmitter finishes the current byte, sends two extra logic-1 bits and stops. The frame then ends off a byte boundary on purpose. A receiver that sees a frame end with a partial byte reports an invalid-symbol error. A byte that arrives while the previous one is still unread overwrites it and raises a sticky overrun flag.

Top module: `serbyte_dbuf`

## Requirements
- R1: After a synchronous reset, tx_empty is 1, while rx_full, rx_overrun, tx_underrun, rx_badsym, tx_bit and tx_eof are all 0.
- R2: A write accepted while the transmitter is idle starts a frame. Two clock edges after the write, tx_bit presents bit 7 of the byte. Each bit_stb edge advances to the next lower bit, so the byte goes out most significant bit first.
- R3: A write accepted while tx_empty is 1 clears tx_empty at that edge. tx_empty is set again at the bit_stb edge that sends the first bit of the byte that was loaded next, not at the end of that byte.
- R4: A write made while tx_empty is 0 is ignored, and the byte already held in the shadow is the one transmitted.
- R5: When the shadow is full at the last bit of a byte, the shadow byte follows with no gap. After the last bit of a byte written with reg_wlast=1, tx_eof is 1 for exactly the following clock cycle and tx_bit returns to 0.
- R6: If the shadow is empty at the last bit of a byte that is not marked last, tx_underrun is set at that edge. tx_bit is then 1 for two further strobes, and after the second of them tx_eof pulses and tx_bit returns to 0.
- R7: On the eighth bit_stb since the last byte boundary, the receive shadow (reg_rdata) takes the eight rx_bit samples, the first one in bit 7, and rx_full is set.
- R8: reg_rd clears rx_full. A byte that completes while rx_full is 1 and no reg_rd is present overwrites reg_rdata and sets rx_overrun.
- R9: rx_eof with a non-zero count of pending bits sets rx_badsym and discards the partial byte. rx_eof on a byte boundary sets no error.
- R10: rx_overrun, tx_underrun and rx_badsym stay set until stat_rd is asserted, which clears all three.
- R11: tx_bit is 0 whenever the transmitter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the transmit data register |
| reg_wdata | input | 8 | Byte to transmit |
| reg_wlast | input | 1 | Marks the written byte as the last of its frame |
| reg_rd | input | 1 | Read strobe for the receive data register; clears rx_full |
| reg_rdata | output | 8 | Receive shadow byte (last byte received) |
| stat_rd | input | 1 | Status read; clears the sticky error flags |
| bit_stb | input | 1 | One pulse per link bit time, shared by both directions |
| tx_bit | output | 1 | Serial transmit data |
| tx_eof | output | 1 | One-cycle pulse when a transmitted frame ends |
| rx_bit | input | 1 | Serial receive data, sampled on bit_stb |
| rx_eof | input | 1 | End of the received frame |
| tx_empty | output | 1 | Transmit shadow can take a byte |
| rx_full | output | 1 | Receive shadow holds an unread byte |
| rx_overrun | output | 1 | Sticky: an unread byte was overwritten |
| tx_underrun | output | 1 | Sticky: the frame was aborted for lack of data |
| rx_badsym | output | 1 | Sticky: a frame ended off a byte boundary |

## Verification
The bench drives the transmitter back into the receiver and sweeps all 256 byte values as one-byte frames. It checks that the empty flag rises after the first bit. A design that raised it at the end of the byte would show 0 there. Two-byte frames with an early write at the wrong time catch a shadow that accepts writes while full, because the wrong byte would then appear on the line. Leaving the first byte unread catches a missing overrun or a receive shadow that is not overwritten. Underrun frames check the two padding ones and the invalid-symbol report they cause. Partial frames of one to seven bits, driven directly, show that a design that counts off by one would accept a short frame.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_PAD   = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic tx_empty;
        logic rx_full;
        logic rx_overrun;
        logic tx_underrun;
        logic rx_badsym;
    } sbd_flags_t;

    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sbd_tx.sv
module sbd_tx
    import sbd_pkg::*;
#(
    parameter int W   = 8,
    parameter int PAD = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         wlast,
    input  logic         stb,
    input  logic         stat_clr,
    output logic         tx_bit,
    output logic         tx_eof,
    output logic         empty,
    output logic         underrun
);
    localparam int CW = cnt_bits(W);
    localparam int PW = cnt_bits(PAD);

    tx_state_e    state;
    logic [W-1:0] shd_data;
    logic         shd_last;
    logic         shd_valid;
    logic [W-1:0] sh;
    logic         sh_last;
    logic [CW-1:0] cnt;
    logic [PW-1:0] pcnt;
    logic         accept;
    logic         last_bit;

    assign accept   = wr && empty;
    assign last_bit = (cnt == CW'(W - 1));
    assign tx_bit   = (state == TX_SHIFT) ? sh[W-1] : (state == TX_PAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TX_IDLE;
            shd_valid <= 1'b0;
            empty     <= 1'b1;
            underrun  <= 1'b0;
            tx_eof    <= 1'b0;
            cnt       <= '0;
            pcnt      <= '0;
        end else begin
            tx_eof <= 1'b0;
            if (stat_clr) underrun <= 1'b0;
            case (state)
                TX_IDLE: begin
                    if (shd_valid) begin
                        sh        <= shd_data;
                        sh_last   <= shd_last;
                        shd_valid <= 1'b0;
                        cnt       <= '0;
                        state     <= TX_SHIFT;
                    end
                end
                TX_SHIFT: begin
                    if (stb) begin
                        sh  <= {sh[W-2:0], 1'b0};
                        cnt <= cnt + 1'b1;
                        if (cnt == '0) empty <= 1'b1;
                        if (last_bit) begin
                            cnt <= '0;
                            if (sh_last) begin
                                state  <= TX_IDLE;
                                tx_eof <= 1'b1;
                            end else if (shd_valid) begin
                                sh        <= shd_data;
                                sh_last   <= shd_last;
                                shd_valid <= 1'b0;
                            end else begin
                                state    <= TX_PAD;
                                pcnt     <= '0;
                                underrun <= 1'b1;
                            end
                        end
                    end
                end
                TX_PAD: begin
                    if (stb) begin
                        pcnt <= pcnt + 1'b1;
                        if (pcnt == PW'(PAD - 1)) begin
                            state  <= TX_IDLE;
                            tx_eof <= 1'b1;
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
            if (accept) begin
                shd_data  <= wdata;
                shd_last  <= wlast;
                shd_valid <= 1'b1;
                empty     <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sbd_rx.sv
module sbd_rx
    import sbd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic         bit_in,
    input  logic         eof_in,
    input  logic         rd,
    input  logic         stat_clr,
    output logic [W-1:0] data,
    output logic         full,
    output logic         overrun,
    output logic         badsym
);
    localparam int CW = cnt_bits(W);

    logic [W-1:0]  rsh;
    logic [W-1:0]  rsh_nxt;
    logic [CW-1:0] rcnt;
    logic [CW-1:0] rcnt_nxt;
    logic          done;

    always_comb begin
        rsh_nxt  = {rsh[W-2:0], bit_in};
        done     = stb && (rcnt == CW'(W - 1));
        rcnt_nxt = rcnt;
        if (stb) rcnt_nxt = done ? '0 : rcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rcnt    <= '0;
            full    <= 1'b0;
            overrun <= 1'b0;
            badsym  <= 1'b0;
        end else begin
            if (stat_clr) begin
                overrun <= 1'b0;
                badsym  <= 1'b0;
            end
            if (rd) full <= 1'b0;
            if (stb) rsh <= rsh_nxt;
            rcnt <= rcnt_nxt;
            if (done) begin
                data <= rsh_nxt;
                full <= 1'b1;
                if (full && !rd) overrun <= 1'b1;
            end
            if (eof_in) begin
                if (rcnt_nxt != '0) badsym <= 1'b1;
                rcnt <= '0;
            end
        end
    end

endmodule

// File: rtl/serbyte_dbuf.sv
module serbyte_dbuf
    import sbd_pkg::*;
#(
    parameter int W   = 8,
    parameter int PAD = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_wr,
    input  logic [W-1:0] reg_wdata,
    input  logic         reg_wlast,
    input  logic         reg_rd,
    output logic [W-1:0] reg_rdata,
    input  logic         stat_rd,
    input  logic         bit_stb,
    output logic         tx_bit,
    output logic         tx_eof,
    input  logic         rx_bit,
    input  logic         rx_eof,
    output logic         tx_empty,
    output logic         rx_full,
    output logic         rx_overrun,
    output logic         tx_underrun,
    output logic         rx_badsym
);
    sbd_flags_t flags;

    sbd_tx #(.W(W), .PAD(PAD)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .wlast    (reg_wlast),
        .stb      (bit_stb),
        .stat_clr (stat_rd),
        .tx_bit   (tx_bit),
        .tx_eof   (tx_eof),
        .empty    (flags.tx_empty),
        .underrun (flags.tx_underrun)
    );

    sbd_rx #(.W(W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .stb      (bit_stb),
        .bit_in   (rx_bit),
        .eof_in   (rx_eof),
        .rd       (reg_rd),
        .stat_clr (stat_rd),
        .data     (reg_rdata),
        .full     (flags.rx_full),
        .overrun  (flags.rx_overrun),
        .badsym   (flags.rx_badsym)
    );

    assign tx_empty    = flags.tx_empty;
    assign rx_full     = flags.rx_full;
    assign rx_overrun  = flags.rx_overrun;
    assign tx_underrun = flags.tx_underrun;
    assign rx_badsym   = flags.rx_badsym;

endmodule

// File: rtl/sbd_chk.sv
module sbd_chk (
    input logic clk,
    input logic rst,
    input logic reg_wr,
    input logic reg_rd,
    input logic stat_rd,
    input logic bit_stb,
    input logic rx_eof,
    input logic tx_bit,
    input logic tx_eof,
    input logic tx_empty,
    input logic rx_full,
    input logic rx_overrun,
    input logic tx_underrun,
    input logic rx_badsym
);
    AST_EMPTY_SET_BY_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_empty) |-> $past(bit_stb)); // R3
    AST_EMPTY_CLR_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_empty) |-> $past(reg_wr)); // R3
    AST_FULL_SET_BY_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> $past(bit_stb)); // R7
    AST_FULL_CLR_BY_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_full) |-> $past(reg_rd)); // R8
    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_full && bit_stb)); // R8
    AST_UNDERRUN_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_underrun) |-> $past(bit_stb)); // R6
    AST_BADSYM_ON_EOF: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_badsym) |-> $past(rx_eof)); // R9
    AST_EOF_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
        tx_eof |-> !tx_bit); // R11
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(tx_underrun) && !$past(stat_rd)) |-> tx_underrun); // R10
    AST_BADSYM_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(rx_badsym) && !$past(stat_rd)) |-> rx_badsym); // R10
endmodule

bind serbyte_dbuf sbd_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .stat_rd     (stat_rd),
    .bit_stb     (bit_stb),
    .rx_eof      (rx_eof),
    .tx_bit      (tx_bit),
    .tx_eof      (tx_eof),
    .tx_empty    (tx_empty),
    .rx_full     (rx_full),
    .rx_overrun  (rx_overrun),
    .tx_underrun (tx_underrun),
    .rx_badsym   (rx_badsym)
);

// File: tb/serbyte_dbuf_test.sv
module serbyte_dbuf_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_wlast = 1'b0;
    logic       reg_rd = 1'b0;
    logic       stat_rd = 1'b0;
    logic       bit_stb = 1'b0;
    logic       lb = 1'b1;
    logic       rx_drv = 1'b0;
    logic       eof_drv = 1'b0;
    logic [7:0] reg_rdata;
    logic       tx_bit, tx_eof, tx_empty, rx_full, rx_overrun, tx_underrun, rx_badsym;
    logic       rx_bit, rx_eof;
    int         vectors = 0;
    int         miscompares = 0;

    assign rx_bit = lb ? tx_bit : rx_drv;
    assign rx_eof = lb ? tx_eof : eof_drv;

    always #10 clk = ~clk;

    serbyte_dbuf uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_wlast(reg_wlast), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .stat_rd(stat_rd), .bit_stb(bit_stb), .tx_bit(tx_bit), .tx_eof(tx_eof),
        .rx_bit(rx_bit), .rx_eof(rx_eof), .tx_empty(tx_empty), .rx_full(rx_full),
        .rx_overrun(rx_overrun), .tx_underrun(tx_underrun), .rx_badsym(rx_badsym)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input int act, input int exp, input string tag);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic strobe();
        bit_stb = 1'b1;
        tick();
        bit_stb = 1'b0;
    endtask

    task automatic write(input logic [7:0] v, input logic last);
        reg_wr = 1'b1; reg_wdata = v; reg_wlast = last;
        tick();
        reg_wr = 1'b0; reg_wlast = 1'b0;
    endtask

    task automatic pulse_rd();
        reg_rd = 1'b1; tick(); reg_rd = 1'b0;
    endtask

    task automatic pulse_stat();
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        eq(tx_empty, 1, "R1 tx_empty");
        eq(rx_full, 0, "R1 rx_full");
        eq(rx_overrun, 0, "R1 rx_overrun");
        eq(tx_underrun, 0, "R1 tx_underrun");
        eq(rx_badsym, 0, "R1 rx_badsym");
        eq(tx_bit, 0, "R1/R11 tx_bit");
        eq(tx_eof, 0, "R1 tx_eof");

        // Sweep: every byte value as a one-byte frame, looped back
        for (int v = 0; v < 256; v++) begin
            write(8'(v), 1'b1);
            eq(tx_empty, 0, "R3 empty cleared by write");
            tick();
            for (int i = 7; i >= 0; i--) begin
                eq(tx_bit, (v >> i) & 1, "R2 serial bit");
                strobe();
                if (i == 7) eq(tx_empty, 1, "R3 empty after first bit");
            end
            eq(tx_eof, 1, "R5 eof pulse");
            eq(tx_bit, 0, "R11 idle low");
            eq(rx_full, 1, "R7 full set");
            eq(reg_rdata, v, "R7 received byte");
            tick();
            eq(tx_eof, 0, "R5 eof single cycle");
            eq(rx_badsym, 0, "R9 boundary eof ok");
            pulse_rd();
            eq(rx_full, 0, "R8 read clears full");
        end

        // Two-byte frames, ignored early write, overrun on unread first byte
        for (int k = 0; k < 16; k++) begin
            logic [7:0] a, b;
            logic [15:0] fr;
            a = 8'(k * 17) ^ 8'h5A;
            b = ~a + 8'(k * 3);
            write(a, 1'b0);
            write(~a ^ 8'h3C, 1'b1);   // R4 must be ignored: empty is 0
            fr = {a, b};
            eq(tx_bit, a[7], "R4 first byte kept");
            strobe();
            eq(tx_empty, 1, "R3 empty after first bit");
            write(b, 1'b1);
            eq(tx_empty, 0, "R3 empty cleared");
            for (int i = 14; i >= 0; i--) begin
                eq(tx_bit, fr[i], "R4/R5 frame bit");
                strobe();
                if (i == 8) begin
                    eq(rx_full, 1, "R7 first byte full");
                    eq(reg_rdata, a, "R7 first byte data");
                    eq(tx_empty, 0, "R5 no gap, second byte loaded");
                end
                if (i == 7) eq(tx_empty, 1, "R3 empty after second byte first bit");
            end
            eq(tx_eof, 1, "R5 eof after last byte");
            eq(rx_overrun, 1, "R8 overrun set");
            eq(reg_rdata, b, "R8 shadow overwritten");
            tick();
            eq(rx_overrun, 1, "R10 overrun sticky");
            pulse_rd();
            eq(rx_full, 0, "R8 read clears full");
            pulse_stat();
            eq(rx_overrun, 0, "R10 stat_rd clears overrun");
        end

        // Underrun: byte then two padding ones
        for (int k = 0; k < 8; k++) begin
            logic [7:0] v;
            v = 8'(k * 37 + 3);
            write(v, 1'b0);
            tick();
            for (int i = 7; i >= 0; i--) begin
                eq(tx_bit, v[i], "R2 underrun byte bit");
                strobe();
            end
            eq(tx_underrun, 1, "R6 underrun set");
            eq(tx_bit, 1, "R6 pad bit 1");
            eq(tx_eof, 0, "R6 no eof yet");
            eq(reg_rdata, v, "R7 byte before abort");
            pulse_rd();
            eq(tx_bit, 1, "R6 pad bit 1 held");
            strobe();
            eq(tx_bit, 1, "R6 pad bit 2");
            strobe();
            eq(tx_eof, 1, "R6 eof after pads");
            eq(tx_bit, 0, "R6/R11 line low");
            tick();
            eq(rx_badsym, 1, "R9 invalid symbol");
            eq(rx_full, 0, "R9 partial byte discarded");
            tick();
            eq(tx_underrun, 1, "R10 underrun sticky");
            pulse_stat();
            eq(tx_underrun, 0, "R10 clear underrun");
            eq(rx_badsym, 0, "R10 clear badsym");
        end

        // Direct receive: partial frames of 1..7 bits and a full one
        lb = 1'b0;
        for (int n = 1; n <= 8; n++) begin
            logic [7:0] pat;
            pat = 8'(n * 29 + 1);
            for (int i = 7; i >= 8 - n; i--) begin
                rx_drv = pat[i];
                strobe();
            end
            eof_drv = 1'b1; tick(); eof_drv = 1'b0;
            if (n < 8) begin
                eq(rx_badsym, 1, "R9 short frame flagged");
                eq(rx_full, 0, "R9 short frame no byte");
                pulse_stat();
                eq(rx_badsym, 0, "R10 clear badsym");
            end else begin
                eq(rx_badsym, 0, "R9 full byte no error");
                eq(rx_full, 1, "R7 full set");
                eq(reg_rdata, pat, "R7 first bit in MSB");
                pulse_rd();
            end
        end
        eq(tx_bit, 0, "R11 idle after receive traffic");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule